// File: doc/BRIEF.md
# Serial Register-Access Slave

This block is the slave end of a four-wire serial link that gives an external master read and write access to a small register file. Each transfer is a 16-bit frame, most significant bit first. The first byte is a command: a direction flag, a 5-bit register address, a parity bit and one spare bit. The second byte carries the write data. While the command byte arrives, the block returns an 8-bit status word supplied by the chip. During the second byte it returns the current contents of the addressed register.

The serial pins are brought into the system clock domain through two-flop synchronisers. All edges are found from the synchronised levels, so the system clock must run at least four times faster than the serial clock. The register file itself sits outside the block. The block presents a read address and expects read data back in the same cycle. Writes leave the block as a single-cycle strobe with an address and a data byte. A write is only issued after the chip select has been released.

A three-state controller sequences each transfer. It starts in IDLE, with select high and the output driver off. It moves to ACTIVE when it sees a select fall, and while in ACTIVE the bit shifting runs. It moves from ACTIVE to FINISH when it sees a select rise. FINISH lasts one cycle, during which the frame is judged and the write or error pulses are raised. From FINISH the controller returns to IDLE, or goes straight back to ACTIVE if a new select fall has already been seen.

Top module: `spi_regif_slave`

## Requirements
- R1: `miso_oe` is 1 only while a frame is in progress with select low. After reset and between frames it is 0, and `wr_en`, `parity_err` and `length_err` are 0 after reset.
- R2: `status_in` is captured when the select falls. Its 8 bits, bit 7 first, are driven on `miso`, each bit changing after a rising serial-clock edge. Rising edges 1 to 8 of the frame carry these bits.
- R3: `mosi` is sampled on falling serial-clock edges. Frame bit 15 is the direction (1 = read, 0 = write). Bits 14..10 are the address, bit 9 is the parity bit and bit 8 is ignored. Bits 7..0 are the write data.
- R4: The addressed register value is taken from `rd_data` at the falling edge that samples the parity bit. It is shifted out bit 7 first on rising edges 9 to 16. On a write frame this is the value held before the write.
- R5: A read of an address at or above `NUM_REGS` (24 by default) returns 0x00, whatever `rd_data` shows.
- R6: `wr_en` pulses for one cycle, with `wr_addr` and `wr_data` taken from the frame, after select rises. It pulses only when exactly 16 falling edges were seen, the direction is write, the parity is correct and the address is below `NUM_REGS`. A write to an unmapped address raises no pulse at all.
- R7: The parity is correct when the count of ones across the direction bit, the address and the parity bit is even. A write frame of 16 edges with wrong parity raises a one-cycle `parity_err` and no write. Read frames never raise it.
- R8: A frame with any falling-edge count other than 16 (including 0, 15, 17 and 32) raises a one-cycle `length_err`. It raises no write and no parity error, and the edge count saturates so that it cannot wrap back to 16.
- R9: A read frame never writes, whatever its second byte holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ss_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the `miso` driver |
| status_in | input | 8 | Status word returned during the command byte |
| rd_addr | output | 5 | Register address being decoded |
| rd_data | input | 8 | Register file read data, combinational on `rd_addr` |
| wr_en | output | 1 | One-cycle write strobe |
| wr_addr | output | 5 | Write address |
| wr_data | output | 8 | Write data |
| parity_err | output | 1 | One-cycle pulse: write frame with wrong parity |
| length_err | output | 1 | One-cycle pulse: frame without exactly 16 edges |

## Verification
The hardest case to reach is the pre-write readback. The byte returned during a write frame must be the old register value, while the new value only lands after the select rises. The bench therefore writes the same address twice in a row and checks the second frame's returned byte against the first frame's data. The bench also drives deliberate junk on `rd_data` for unmapped addresses, so that a zero readback cannot pass by accident. Short, long, empty and 32-edge frames are driven with otherwise valid write commands. This shows that only the edge count blocks them.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_FINISH
    } frame_state_e;

endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);

    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {(STAGES+1){RST_VAL}};
        else        chain_q <= {chain_q[STAGES-1:0], din};
    end

    assign level = chain_q[STAGES-1];
    assign rise  =  chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall  = ~chain_q[STAGES-1] &  chain_q[STAGES];

endmodule

// File: rtl/spi_rx_path.sv
module spi_rx_path #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              fall_en,
    input  logic              mosi_bit,
    output logic [$clog2(ADDR_W+DATA_W+5)-1:0] edge_cnt,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cap_strobe,
    output logic              f_rw,
    output logic [ADDR_W-1:0] f_addr,
    output logic              f_par,
    output logic [DATA_W-1:0] f_data
);

    localparam int FRAME_W = ADDR_W + DATA_W + 3;
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam int SAT     = FRAME_W + 1;
    localparam int PAR_IDX = ADDR_W + 1;

    logic [FRAME_W-1:0] shreg_q;
    logic [CNT_W-1:0]   cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (load) begin
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (fall_en) begin
            shreg_q <= {shreg_q[FRAME_W-2:0], mosi_bit};
            if (cnt_q != CNT_W'(SAT)) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign edge_cnt   = cnt_q;
    assign cur_addr   = shreg_q[ADDR_W-1:0];
    assign cap_strobe = fall_en && (cnt_q == CNT_W'(PAR_IDX));
    assign f_rw       = shreg_q[FRAME_W-1];
    assign f_addr     = shreg_q[FRAME_W-2 -: ADDR_W];
    assign f_par      = shreg_q[DATA_W+1];
    assign f_data     = shreg_q[DATA_W-1:0];

    a_r8_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(SAT));

endmodule

// File: rtl/spi_tx_path.sv
module spi_tx_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              rise_en,
    input  logic [DATA_W-1:0] status_in,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] cap_data,
    output logic              miso
);

    localparam int RCNT_W = $clog2(2*DATA_W + 1);
    localparam int LAST   = 2*DATA_W;

    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] reg_q;
    logic [RCNT_W-1:0] rcnt_q;
    logic              miso_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            reg_q  <= '0;
            rcnt_q <= '0;
            miso_q <= 1'b0;
        end else if (load) begin
            stat_q <= status_in;
            reg_q  <= '0;
            rcnt_q <= '0;
            miso_q <= 1'b0;
        end else begin
            if (cap_en) reg_q <= cap_data;
            if (rise_en) begin
                if (rcnt_q < RCNT_W'(DATA_W)) begin
                    miso_q <= stat_q[DATA_W-1];
                    stat_q <= {stat_q[DATA_W-2:0], 1'b0};
                end else begin
                    miso_q <= reg_q[DATA_W-1];
                    reg_q  <= {reg_q[DATA_W-2:0], 1'b0};
                end
                if (rcnt_q != RCNT_W'(LAST)) rcnt_q <= rcnt_q + 1'b1;
            end
        end
    end

    assign miso = miso_q;

    a_r2_miso_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso_q) |-> $past(rise_en || load));

endmodule

// File: rtl/spi_regif_slave.sv
module spi_regif_slave
    import spi_regif_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 8,
    parameter int NUM_REGS    = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_n,
    input  logic              sck,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    input  logic [DATA_W-1:0] status_in,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              parity_err,
    output logic              length_err
);

    localparam int FRAME_W = ADDR_W + DATA_W + 3;
    localparam int CNT_W   = $clog2(FRAME_W + 2);

    logic ss_lvl, ss_rise, ss_fall;
    logic sck_lvl, sck_rise, sck_fall;
    logic mosi_lvl, mosi_rise_nc, mosi_fall_nc;

    spi_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ss (
        .clk(clk), .rst_n(rst_n), .din(ss_n),
        .level(ss_lvl), .rise(ss_rise), .fall(ss_fall));
    spi_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
        .clk(clk), .rst_n(rst_n), .din(sck),
        .level(sck_lvl), .rise(sck_rise), .fall(sck_fall));
    spi_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
        .clk(clk), .rst_n(rst_n), .din(mosi),
        .level(mosi_lvl), .rise(mosi_rise_nc), .fall(mosi_fall_nc));

    frame_state_e state_q, state_d;

    logic              load, rise_en, fall_en, cap_strobe;
    logic [CNT_W-1:0]  edge_cnt;
    logic [ADDR_W-1:0] cur_addr, f_addr;
    logic              f_rw, f_par;
    logic [DATA_W-1:0] f_data, cap_data;
    logic              frame_ok, par_ok, mapped;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (ss_fall) state_d = ST_ACTIVE;
            ST_ACTIVE: if (ss_rise) state_d = ST_FINISH;
            ST_FINISH: state_d = ss_fall ? ST_ACTIVE : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign load     = ss_fall && (state_q != ST_ACTIVE);
    assign rise_en  = sck_rise && (state_q == ST_ACTIVE);
    assign fall_en  = sck_fall && (state_q == ST_ACTIVE);
    assign rd_addr  = cur_addr;
    assign cap_data = (int'(cur_addr) < NUM_REGS) ? rd_data : '0;

    spi_rx_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .load(load), .fall_en(fall_en),
        .mosi_bit(mosi_lvl), .edge_cnt(edge_cnt), .cur_addr(cur_addr),
        .cap_strobe(cap_strobe), .f_rw(f_rw), .f_addr(f_addr),
        .f_par(f_par), .f_data(f_data));

    spi_tx_path #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(load), .rise_en(rise_en),
        .status_in(status_in), .cap_en(cap_strobe), .cap_data(cap_data),
        .miso(miso));

    assign frame_ok = (edge_cnt == CNT_W'(FRAME_W));
    assign par_ok   = ~^{f_rw, f_addr, f_par};
    assign mapped   = int'(f_addr) < NUM_REGS;

    always_comb begin
        miso_oe    = 1'b0;
        wr_en      = 1'b0;
        parity_err = 1'b0;
        length_err = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ACTIVE: miso_oe = 1'b1;
            ST_FINISH: begin
                wr_en      = frame_ok && !f_rw && par_ok && mapped;
                parity_err = frame_ok && !f_rw && !par_ok;
                length_err = !frame_ok;
            end
            default: ;
        endcase
    end

    assign wr_addr = f_addr;
    assign wr_data = f_data;

    a_r1_oe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> !$past(ss_lvl));
    a_r6_write_follows_release: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(ss_rise));
    a_r8_length_follows_release: assert property (@(posedge clk) disable iff (!rst_n)
        length_err |-> $past(ss_rise));
    a_r7_error_excludes_write: assert property (@(posedge clk) disable iff (!rst_n)
        parity_err |-> (!wr_en && !length_err));
    a_r6_single_cycle_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

endmodule

// File: tb/test_spi_regif_slave.sv
module test_spi_regif_slave;

    localparam int NREG = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ss_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic       miso, miso_oe;
    logic [7:0] status_in = 8'h00;
    logic [4:0] rd_addr;
    logic [7:0] rd_data;
    logic       wr_en, parity_err, length_err;
    logic [4:0] wr_addr;
    logic [7:0] wr_data;

    int checks = 0;
    int errors = 0;

    logic [7:0] env_regs [32];
    logic [7:0] shadow   [32];

    always #2 clk = ~clk;

    spi_regif_slave i_spi_regif_slave (
        .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sck(sck), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .status_in(status_in),
        .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .parity_err(parity_err), .length_err(length_err));

    assign rd_data = (int'(rd_addr) < NREG) ? env_regs[rd_addr] : 8'hA5;

    always @(posedge clk) if (wr_en) env_regs[wr_addr] <= wr_data;

    function automatic logic good_par(input logic rw, input logic [4:0] a);
        return ^{rw, a};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_frame(input logic rw, input logic [4:0] a, input logic p,
                             input logic x, input logic [7:0] d, input int nbits);
        logic [15:0] word, got, exp_rx, mask;
        logic [7:0]  stat;
        int n_wr, n_par, n_len;
        logic [4:0] seen_a;
        logic [7:0] seen_d;
        logic e_wr, e_par, e_len;
        word = {rw, a, p, x, d};
        stat = 8'($urandom);
        status_in = stat;
        exp_rx = {stat, (int'(a) < NREG) ? shadow[a] : 8'h00};
        e_len = (nbits != 16);
        e_wr  = !e_len && !rw && (p == good_par(rw, a)) && (int'(a) < NREG);
        e_par = !e_len && !rw && (p != good_par(rw, a));
        got = '0; mask = '0;
        n_wr = 0; n_par = 0; n_len = 0; seen_a = '0; seen_d = '0;
        @(negedge clk) ss_n = 1'b0;
        repeat (8) @(negedge clk);
        check("R1 oe during frame", miso_oe, 1);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 16) ? word[15-i] : 1'($urandom);
            sck = 1'b1;
            repeat (7) @(negedge clk);
            if (i < 16) begin got[15-i] = miso; mask[15-i] = 1'b1; end
            sck = 1'b0;
            repeat (8) @(negedge clk);
        end
        ss_n = 1'b1;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (wr_en) begin n_wr++; seen_a = wr_addr; seen_d = wr_data; end
            if (parity_err) n_par++;
            if (length_err) n_len++;
        end
        check("R1 oe off after frame", miso_oe, 0);
        check("R2/R4/R5 returned bits", got & mask, exp_rx & mask);
        check("R6/R9 write count", n_wr, e_wr ? 1 : 0);
        if (e_wr) check("R6 write addr/data", {seen_a, seen_d}, {a, d});
        check("R7 parity error", n_par, e_par ? 1 : 0);
        check("R8 length error", n_len, e_len ? 1 : 0);
        if (e_wr) shadow[a] = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 32; i++) begin
            env_regs[i] = 8'($urandom);
            shadow[i]   = env_regs[i];
        end
        repeat (4) @(negedge clk);
        check("R1 reset oe", miso_oe, 0);
        check("R1 reset pulses", {wr_en, parity_err, length_err}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        run_frame(1'b1, 5'd3, good_par(1'b1, 5'd3), 1'b0, 8'hFF, 16);   // R2 R4 read
        run_frame(1'b0, 5'd3, good_par(1'b0, 5'd3), 1'b0, 8'h5A, 16);   // R6 write
        run_frame(1'b0, 5'd3, good_par(1'b0, 5'd3), 1'b0, 8'hC3, 16);   // R4 pre-write value 5A
        run_frame(1'b1, 5'd3, good_par(1'b1, 5'd3), 1'b0, 8'h00, 16);   // R4 reads C3
        run_frame(1'b0, 5'd7, ~good_par(1'b0, 5'd7), 1'b0, 8'h11, 16);  // R7 bad parity write
        run_frame(1'b1, 5'd7, ~good_par(1'b1, 5'd7), 1'b0, 8'h22, 16);  // R7 reads ignore parity
        run_frame(1'b0, 5'd9, good_par(1'b0, 5'd9), 1'b0, 8'h33, 15);   // R8 short
        run_frame(1'b0, 5'd9, good_par(1'b0, 5'd9), 1'b0, 8'h44, 17);   // R8 long
        run_frame(1'b0, 5'd9, good_par(1'b0, 5'd9), 1'b0, 8'h55, 32);   // R8 saturation
        run_frame(1'b0, 5'd9, good_par(1'b0, 5'd9), 1'b0, 8'h66, 0);    // R8 empty
        run_frame(1'b1, 5'd30, good_par(1'b1, 5'd30), 1'b0, 8'h00, 16); // R5 unmapped read
        run_frame(1'b0, 5'd28, good_par(1'b0, 5'd28), 1'b0, 8'h77, 16); // R6 unmapped write
        run_frame(1'b0, 5'd12, good_par(1'b0, 5'd12), 1'b1, 8'h88, 16); // R3 spare bit ignored
        run_frame(1'b1, 5'd12, good_par(1'b1, 5'd12), 1'b1, 8'h99, 16); // R9 read data ignored

        for (int k = 0; k < 60; k++) begin
            logic rw_r, p_r;
            logic [4:0] a_r;
            int len_r;
            rw_r  = 1'($urandom);
            a_r   = 5'($urandom);
            p_r   = ($urandom_range(0, 4) == 0) ? ~good_par(rw_r, a_r) : good_par(rw_r, a_r);
            len_r = ($urandom_range(0, 5) == 0) ? int'($urandom_range(10, 20)) : 16;
            run_frame(rw_r, a_r, p_r, 1'($urandom), 8'($urandom), len_r);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule